// File: doc/BRIEF.md
# Power Mode Sequencer with Wake Handling

This block is the mode controller of a supervisory companion chip that powers and watches a host microcontroller. It tracks the modes Off, Reset, Normal Request, Normal, Standby, Stop and Sleep, and it moves between them on single-cycle event strobes. These strobes come from the rest of the chip: power-up complete, supply low, watchdog expiry, a watchdog trigger outside its open window, a watchdog configuration write, Stop or Sleep commands, the chip-select rising edge, and several wake sources.

Normal Request is the checkpoint where the host must configure the watchdog. Its timeout fallback depends on how it was entered. After power-up, a fault or a Stop wake, the block keeps looping through Reset. After a Sleep wake, it falls back to Sleep. A wake from Stop skips Reset and is reported by a fixed-width, unmaskable interrupt pulse. Every wake latches sticky source flags, which clear only on a clear strobe. All durations are parameters in clock cycles.

Top module: `pwrseq_top`

## Requirements
- R1: After `rstN` is released the block is in Off (mode code 0): `rstPinN` low, `irqPulse` low, all flags 0. Off is left only on `evPowerUp`, which enters Reset. Mode codes: 0 Off, 1 Reset, 2 Normal Request, 3 Normal, 4 Standby, 5 Stop, 6 Sleep.
- R2: Reset lasts exactly `RST_CYC` cycles with `rstPinN` low, then Normal Request is entered and `rstPinN` goes high.
- R3: In any mode but Off, `evSupplyLow` or `evWdBadTrig` moves the block to Reset on the next cycle. So does a qualified `evWdTimeout` (see R11). This takes priority over every other event.
- R4: In Normal Request, `evWdCfg` moves the block to Normal when `cfgStandby`=0 and to Standby when `cfgStandby`=1.
- R5: If Normal Request was entered from Reset after power-up or a fault, or directly from a Stop wake, and no configuration arrives within `CFG_CYC` cycles, the block goes to Reset.
- R6: If Normal Request was reached through a Sleep wake and `CFG_CYC` cycles pass without configuration, the block returns to Sleep.
- R7: In Normal or Standby, `cmdStop` and `cmdSleep` are held pending without a mode change. They take effect on the next `csRise`, which may be in the same cycle, and Stop wins over Sleep.
- R8: In Stop, any of `csRise`, `wakeCan`, `wakeIn`, `wakeForced` or `wakeOvercur` moves the block straight to Normal Request. `irqPulse` then goes high on the following cycle for exactly `IRQ_CYC` cycles.
- R9: In Sleep, `wakeCan`, `wakeIn` or `wakeForced` moves the block to Reset without an interrupt. `csRise` and `wakeOvercur` have no effect in Sleep.
- R10: A taken wake sets `wakeFlags[0]` on `wakeCan` and `wakeFlags[1+i]` on `wakeIn[i]`. Forced, overcurrent and chip-select wakes set no flag. Simultaneous sources latch together and give one pulse. Flags stay set until `flagClr`, and a new set wins over a clear in the same cycle.
- R11: `evWdTimeout` is ignored in Sleep. In Stop it acts only when `wdRunInStop`=1, and then it leads through Reset into Normal Request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evPowerUp | input | 1 | Power-up complete strobe |
| evSupplyLow | input | 1 | Supply-low strobe |
| evWdTimeout | input | 1 | Watchdog expiry strobe |
| evWdBadTrig | input | 1 | Watchdog trigger in closed window |
| evWdCfg | input | 1 | Watchdog configuration written |
| cfgStandby | input | 1 | Target of configuration: 1 Standby, 0 Normal |
| cmdStop | input | 1 | Stop command strobe |
| cmdSleep | input | 1 | Sleep command strobe |
| csRise | input | 1 | Chip-select low-to-high strobe |
| wdRunInStop | input | 1 | Watchdog keeps running in Stop |
| wakeCan | input | 1 | Bus wake strobe |
| wakeIn | input | NWAKE | Wake-input strobes |
| wakeForced | input | 1 | Forced wake strobe |
| wakeOvercur | input | 1 | Supply overcurrent wake strobe |
| flagClr | input | 1 | Clear wake flags |
| mode | output | 3 | Current mode code |
| rstPinN | output | 1 | Reset pin level, low in Off and Reset |
| irqPulse | output | 1 | Wake interrupt pulse |
| wakeFlags | output | NWAKE+1 | Sticky wake source flags |

## Verification
The assertions assume that every event input is a single-cycle strobe sampled on the rising clock. They also assume the strobes carry no meaning during `rstN` low, and that a fault strobe may coincide with any other event. The bench drives each strobe on a falling edge and removes it on the next one, so each strobe is seen by exactly one rising edge. Faults are never combined with the wake sweeps, so the wake properties see the unfaulted paths. `cfgStandby` and `wdRunInStop` are set one half-cycle before the strobe that uses them and are held steady through it.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    M_OFF     = 3'd0,
    M_RESET   = 3'd1,
    M_NREQ    = 3'd2,
    M_NORMAL  = 3'd3,
    M_STANDBY = 3'd4,
    M_STOP    = 3'd5,
    M_SLEEP   = 3'd6
  } mode_e;

  typedef struct packed {
    logic tmrLoadRst;
    logic tmrLoadCfg;
    logic irqArm;
    logic flagCap;
  } ctl_t;

endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int NWAKE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evPowerUp,
  input  logic             evSupplyLow,
  input  logic             evWdTimeout,
  input  logic             evWdBadTrig,
  input  logic             evWdCfg,
  input  logic             cfgStandby,
  input  logic             cmdStop,
  input  logic             cmdSleep,
  input  logic             csRise,
  input  logic             wdRunInStop,
  input  logic             wakeCan,
  input  logic [NWAKE-1:0] wakeIn,
  input  logic             wakeForced,
  input  logic             wakeOvercur,
  input  logic             tmrDone,
  output mode_e            modeQ,
  output ctl_t             ctl
);

  mode_e modeD;
  logic  fromSleepQ, fromSleepD;
  logic  pendStopQ, pendStopD, pendSleepQ, pendSleepD;
  logic  wdLive, fault, stopWake, sleepWake, wantStop, wantSleep;

  assign wdLive    = (modeQ == M_STOP) ? wdRunInStop : (modeQ != M_SLEEP);
  assign fault     = (modeQ != M_OFF) &&
                     (evSupplyLow || evWdBadTrig || (evWdTimeout && wdLive));
  assign sleepWake = wakeCan || (|wakeIn) || wakeForced;
  assign stopWake  = sleepWake || wakeOvercur || csRise;
  assign wantStop  = pendStopQ || cmdStop;
  assign wantSleep = pendSleepQ || cmdSleep;

  always_comb begin
    modeD      = modeQ;
    fromSleepD = fromSleepQ;
    pendStopD  = 1'b0;
    pendSleepD = 1'b0;
    ctl        = '0;
    if (modeQ == M_OFF) begin
      if (evPowerUp) begin
        modeD          = M_RESET;
        fromSleepD     = 1'b0;
        ctl.tmrLoadRst = 1'b1;
      end
    end else if (fault) begin
      modeD          = M_RESET;
      fromSleepD     = 1'b0;
      ctl.tmrLoadRst = 1'b1;
    end else begin
      case (modeQ)
        M_RESET: begin
          if (tmrDone) begin
            modeD          = M_NREQ;
            ctl.tmrLoadCfg = 1'b1;
          end
        end
        M_NREQ: begin
          if (evWdCfg) begin
            modeD = cfgStandby ? M_STANDBY : M_NORMAL;
          end else if (tmrDone) begin
            if (fromSleepQ) begin
              modeD = M_SLEEP;
            end else begin
              modeD          = M_RESET;
              ctl.tmrLoadRst = 1'b1;
            end
          end
        end
        M_NORMAL, M_STANDBY: begin
          if (csRise && wantStop) begin
            modeD = M_STOP;
          end else if (csRise && wantSleep) begin
            modeD = M_SLEEP;
          end else begin
            pendStopD  = wantStop;
            pendSleepD = wantSleep;
          end
        end
        M_STOP: begin
          if (stopWake) begin
            modeD          = M_NREQ;
            fromSleepD     = 1'b0;
            ctl.tmrLoadCfg = 1'b1;
            ctl.irqArm     = 1'b1;
            ctl.flagCap    = 1'b1;
          end
        end
        M_SLEEP: begin
          if (sleepWake) begin
            modeD          = M_RESET;
            fromSleepD     = 1'b1;
            ctl.tmrLoadRst = 1'b1;
            ctl.flagCap    = 1'b1;
          end
        end
        default: modeD = M_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ      <= M_OFF;
      fromSleepQ <= 1'b0;
      pendStopQ  <= 1'b0;
      pendSleepQ <= 1'b0;
    end else begin
      modeQ      <= modeD;
      fromSleepQ <= fromSleepD;
      pendStopQ  <= pendStopD;
      pendSleepQ <= pendSleepD;
    end
  end

  // R3: hard faults force Reset from any powered mode
  p_fault_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != M_OFF && (evSupplyLow || evWdBadTrig)) |=> modeQ == M_RESET);

  // R4: configuration picks Normal or Standby
  p_cfg_pick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == M_NREQ && evWdCfg && !evSupplyLow && !evWdBadTrig && !evWdTimeout)
    |=> modeQ == ($past(cfgStandby) ? M_STANDBY : M_NORMAL));

  // R7: without a chip-select edge Normal holds
  p_cmd_wait_cs_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == M_NORMAL && !csRise && !evSupplyLow && !evWdBadTrig && !evWdTimeout)
    |=> modeQ == M_NORMAL);

  // R8: a Stop wake goes straight to Normal Request
  p_stop_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == M_STOP && wakeCan && !evSupplyLow && !evWdBadTrig && !evWdTimeout)
    |=> modeQ == M_NREQ);

  // R9: a Sleep wake passes through Reset
  p_sleep_wake_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == M_SLEEP && wakeCan && !evSupplyLow && !evWdBadTrig)
    |=> modeQ == M_RESET);

endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int NWAKE   = 4,
  parameter int RST_CYC = 1000,
  parameter int CFG_CYC = 350000,
  parameter int IRQ_CYC = 100
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctl_t           ctl,
  input  logic           flagClr,
  input  logic           wakeCan,
  input  logic [NWAKE-1:0] wakeIn,
  output logic           tmrDone,
  output logic           irqPulse,
  output logic [NWAKE:0] wakeFlags
);

  localparam int TMR_MAX = (RST_CYC > CFG_CYC) ? RST_CYC : CFG_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int IRQ_W   = $clog2(IRQ_CYC + 1);

  logic [TMR_W-1:0] tmrCnt;
  logic [IRQ_W-1:0] irqCnt;
  logic             irqArmQ;
  logic [NWAKE:0]   newFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (ctl.tmrLoadRst) begin
      tmrCnt <= TMR_W'(RST_CYC);
    end else if (ctl.tmrLoadCfg) begin
      tmrCnt <= TMR_W'(CFG_CYC);
    end else if (tmrCnt != '0) begin
      tmrCnt <= tmrCnt - 1'b1;
    end
  end

  assign tmrDone = (tmrCnt == TMR_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqArmQ <= 1'b0;
      irqCnt  <= '0;
    end else begin
      irqArmQ <= ctl.irqArm;
      if (irqArmQ) begin
        irqCnt <= IRQ_W'(IRQ_CYC);
      end else if (irqCnt != '0) begin
        irqCnt <= irqCnt - 1'b1;
      end
    end
  end

  assign irqPulse = (irqCnt != '0);

  assign newFlags = ctl.flagCap ? {wakeIn, wakeCan} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeFlags <= '0;
    end else begin
      wakeFlags <= (flagClr ? '0 : wakeFlags) | newFlags;
    end
  end

  // R10: flags change only on capture or clear
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!flagClr && !ctl.flagCap) |=> $stable(wakeFlags));

  // R8: an armed interrupt shows up on the pin next cycle
  p_irq_arm_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqArmQ |=> irqPulse);

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int NWAKE   = 4,
  parameter int RST_CYC = 1000,
  parameter int CFG_CYC = 350000,
  parameter int IRQ_CYC = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evPowerUp,
  input  logic             evSupplyLow,
  input  logic             evWdTimeout,
  input  logic             evWdBadTrig,
  input  logic             evWdCfg,
  input  logic             cfgStandby,
  input  logic             cmdStop,
  input  logic             cmdSleep,
  input  logic             csRise,
  input  logic             wdRunInStop,
  input  logic             wakeCan,
  input  logic [NWAKE-1:0] wakeIn,
  input  logic             wakeForced,
  input  logic             wakeOvercur,
  input  logic             flagClr,
  output logic [2:0]       mode,
  output logic             rstPinN,
  output logic             irqPulse,
  output logic [NWAKE:0]   wakeFlags
);

  mode_e modeQ;
  ctl_t  ctl;
  logic  tmrDone;

  pwrseq_ctrl #(.NWAKE(NWAKE)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .evPowerUp(evPowerUp), .evSupplyLow(evSupplyLow), .evWdTimeout(evWdTimeout),
    .evWdBadTrig(evWdBadTrig), .evWdCfg(evWdCfg), .cfgStandby(cfgStandby),
    .cmdStop(cmdStop), .cmdSleep(cmdSleep), .csRise(csRise),
    .wdRunInStop(wdRunInStop), .wakeCan(wakeCan), .wakeIn(wakeIn),
    .wakeForced(wakeForced), .wakeOvercur(wakeOvercur),
    .tmrDone(tmrDone), .modeQ(modeQ), .ctl(ctl)
  );

  pwrseq_dp #(
    .NWAKE(NWAKE), .RST_CYC(RST_CYC), .CFG_CYC(CFG_CYC), .IRQ_CYC(IRQ_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .flagClr(flagClr),
    .wakeCan(wakeCan), .wakeIn(wakeIn),
    .tmrDone(tmrDone), .irqPulse(irqPulse), .wakeFlags(wakeFlags)
  );

  assign mode    = modeQ;
  assign rstPinN = (modeQ != M_RESET) && (modeQ != M_OFF);

  // R8: the interrupt rises only after Normal Request is reached
  p_irq_after_nreq_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPulse) |-> $past(modeQ) == M_NREQ);

  // R9: no interrupt starts out of Sleep
  p_no_irq_sleep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == M_SLEEP) |=> !$rose(irqPulse));

  // R1: Off keeps the reset pin low
  p_off_pin_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == M_OFF && !evPowerUp) |=> (modeQ == M_OFF && !rstPinN));

endmodule

// File: tb/test_pwrseq_top.sv
module test_pwrseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW  = 2;
  localparam int RST = 4;
  localparam int CFG = 12;
  localparam int IRQ = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evPowerUp = 0, evSupplyLow = 0, evWdTimeout = 0, evWdBadTrig = 0;
  logic evWdCfg = 0, cfgStandby = 0, cmdStop = 0, cmdSleep = 0, csRise = 0;
  logic wdRunInStop = 0, wakeCan = 0, wakeForced = 0, wakeOvercur = 0, flagClr = 0;
  logic [NW-1:0] wakeIn = '0;
  logic [2:0] mode;
  logic rstPinN, irqPulse;
  logic [NW:0] wakeFlags;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrseq_top #(.NWAKE(NW), .RST_CYC(RST), .CFG_CYC(CFG), .IRQ_CYC(IRQ)) i_pwrseq_top (
    .clk(clk), .rstN(rstN), .evPowerUp(evPowerUp), .evSupplyLow(evSupplyLow),
    .evWdTimeout(evWdTimeout), .evWdBadTrig(evWdBadTrig), .evWdCfg(evWdCfg),
    .cfgStandby(cfgStandby), .cmdStop(cmdStop), .cmdSleep(cmdSleep), .csRise(csRise),
    .wdRunInStop(wdRunInStop), .wakeCan(wakeCan), .wakeIn(wakeIn),
    .wakeForced(wakeForced), .wakeOvercur(wakeOvercur), .flagClr(flagClr),
    .mode(mode), .rstPinN(rstPinN), .irqPulse(irqPulse), .wakeFlags(wakeFlags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clrAll();
    evPowerUp = 0; evSupplyLow = 0; evWdTimeout = 0; evWdBadTrig = 0;
    evWdCfg = 0; cmdStop = 0; cmdSleep = 0; csRise = 0;
    wakeCan = 0; wakeIn = '0; wakeForced = 0; wakeOvercur = 0; flagClr = 0;
  endtask

  task automatic fire();
    step();
    clrAll();
  endtask

  // from Reset: wait out reset then configure
  task automatic resetToCfg(input bit stby);
    repeat (RST) step();
    chk("R2 reset length", mode, 2);
    cfgStandby = stby; evWdCfg = 1; fire();
    chk("R4 cfg target", mode, stby ? 4 : 3);
  endtask

  task automatic enterStop();
    cmdStop = 1; fire();
    csRise = 1; fire();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nChk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    // R1 reset state
    chk("R1 mode off", mode, 0);
    chk("R1 pin low", rstPinN, 0);
    chk("R1 irq low", irqPulse, 0);
    chk("R1 flags zero", wakeFlags, 0);
    repeat (3) step();
    chk("R1 stays off", mode, 0);
    evPowerUp = 1; fire();
    chk("R1 to reset", mode, 1);
    repeat (RST - 1) step();
    chk("R2 still reset", mode, 1);
    chk("R2 pin low", rstPinN, 0);
    step();
    chk("R2 nreq", mode, 2);
    chk("R2 pin high", rstPinN, 1);
    // R5 power-up origin timeout loops through Reset
    repeat (CFG - 1) step();
    chk("R5 still nreq", mode, 2);
    step();
    chk("R5 back to reset", mode, 1);
    resetToCfg(0);

    // R3 fault sweep over Normal and Standby
    for (int f = 0; f < 3; f++) begin
      for (int s = 0; s < 2; s++) begin
        if (s == 1) begin
          evSupplyLow = 1; fire();
          resetToCfg(1);
        end
        if (f == 0) evSupplyLow = 1;
        else if (f == 1) evWdBadTrig = 1;
        else evWdTimeout = 1;
        evWdCfg = 1;
        fire();
        chk("R3 fault to reset", mode, 1);
        resetToCfg(0);
      end
    end

    // R7 pending command waits for chip-select
    cmdStop = 1; fire();
    repeat (2) step();
    chk("R7 pending no change", mode, 3);
    csRise = 1; fire();
    chk("R7 stop on cs", mode, 5);
    // R11 watchdog gating in Stop
    wdRunInStop = 0; evWdTimeout = 1; fire();
    chk("R11 wd ignored in stop", mode, 5);
    wdRunInStop = 1; evWdTimeout = 1; fire();
    chk("R11 wd in stop resets", mode, 1);
    wdRunInStop = 0;
    resetToCfg(0);

    // R8 R10 sweep over all Stop wake combinations
    for (int c = 1; c < 64; c++) begin
      int hi;
      flagClr = 1; fire();
      chk("R10 clear", wakeFlags, 0);
      if (c[0]) begin
        cmdStop = 1; csRise = 1; fire();
      end else begin
        enterStop();
      end
      chk("R7 in stop", mode, 5);
      csRise = c[0]; wakeCan = c[1]; wakeIn = c[3:2];
      wakeForced = c[4]; wakeOvercur = c[5];
      fire();
      chk("R8 stop to nreq", mode, 2);
      chk("R8 irq not yet", irqPulse, 0);
      chk("R10 stop flags", wakeFlags, {c[3:2], c[1]});
      hi = 0;
      for (int i = 0; i < IRQ + 2; i++) begin
        step();
        if (irqPulse) hi++;
      end
      chk("R8 irq width", hi, IRQ);
      chk("R10 flags held", wakeFlags, {c[3:2], c[1]});
      evWdCfg = 1; cfgStandby = c[0]; fire();
      chk("R4 after stop", mode, c[0] ? 4 : 3);
    end

    // R5 Stop origin timeout goes to Reset
    enterStop();
    csRise = 1; fire();
    repeat (CFG - 1) step();
    chk("R5 stop origin nreq", mode, 2);
    step();
    chk("R5 stop origin reset", mode, 1);
    resetToCfg(0);

    // R9 R6 R11 Sleep
    flagClr = 1; fire();
    cmdSleep = 1; fire();
    chk("R7 sleep pending", mode, 3);
    csRise = 1; fire();
    chk("R7 sleep on cs", mode, 6);
    csRise = 1; wakeOvercur = 1; fire();
    chk("R9 ignored in sleep", mode, 6);
    evWdTimeout = 1; fire();
    chk("R11 wd ignored in sleep", mode, 6);
    chk("R9 no flags", wakeFlags, 0);
    chk("R9 no irq", irqPulse, 0);
    for (int c = 1; c < 16; c++) begin
      int hi;
      flagClr = 1; fire();
      chk("R10 clear sleep", wakeFlags, 0);
      wakeCan = c[0]; wakeIn = c[2:1]; wakeForced = c[3];
      fire();
      chk("R9 sleep to reset", mode, 1);
      chk("R10 sleep flags", wakeFlags, {c[2:1], c[0]});
      hi = 0;
      for (int i = 0; i < RST; i++) begin
        step();
        if (irqPulse) hi++;
      end
      chk("R9 via reset to nreq", mode, 2);
      repeat (CFG - 1) begin
        step();
        if (irqPulse) hi++;
      end
      chk("R9 no irq on sleep wake", hi, 0);
      chk("R6 nreq before timeout", mode, 2);
      step();
      chk("R6 back to sleep", mode, 6);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule